// File: doc/BRIEF.md
# Compact-instruction execute unit

This block executes a small set of 16-bit instructions against two banks of sixteen 32-bit registers, one holding data and one holding addresses. Each cycle in which `in_valid` is high it accepts one instruction word together with the address that word was fetched from. It returns the address of the following instruction and commits the instruction's register and flag effects on the next rising clock edge. Instruction length comes from the word's least significant bit, so longer words pass through without effect apart from the PC step. Register contents and the status word can be read at any time through two combinational read ports.

The supported operations are add and subtract on data registers with overflow tracking, a plain add on address registers, bitwise AND/OR/XOR, register and constant moves between and within the banks, conditional add and conditional move, and signed equal/less-than compares. Data register 15 plays a special role. It is the predicate of the conditional forms (tested for zero or nonzero). It is the implicit destination of compares. It is an alternative first source or destination for some add/subtract variants. Overflow is tracked in four status bits: two are rewritten by each flag-setting operation and two are sticky and collect the first two until reset.

Words are decoded as follows: opcode in bits 7:0, first register field `rd` in bits 11:8, second register field `rs` (or the 4-bit constant `k`) in bits 15:12. In a 16-bit word bits 31:16 are ignored. "sext(k)" means the constant sign-extended to 32 bits, "zext(k)" zero-extended.

Top module: `cix_unit`

## Requirements
- R1: `next_pc` is `pc_in + 2` when `instr[0]` is 0 and `pc_in + 4` when `instr[0]` is 1, with 32-bit wrap-around.
- R2: A word with `instr[0]` = 1, a 16-bit word whose opcode is not listed below, or any cycle with `in_valid` low leaves every register and the status word unchanged.
- R3: Opcodes 0x02 (d[rd] = d[rd] + sext(k)), 0x20 (d[rd] = d[rd] + d[rs]) and 0x3E (d[rd] = d[rd] - d[rs]) set status bit 30 to the signed overflow of the operation, set bit 28 to result[31] XOR result[30], OR bit 30's new value into bit 29 and OR bit 28's new value into bit 27. Bits 29 and 27 stay set until reset.
- R4: The implicit-register variants set flags as in R3 and compute 0x04: d[rd] = d15 + sext(k); 0x06: d15 = d[rd] + sext(k); 0x22: d[rd] = d15 + d[rs]; 0x24: d15 = d[rd] + d[rs]; 0x40: d[rd] = d15 - d[rs]; 0x42: d15 = d[rd] - d[rs].
- R5: Opcode 0x16 writes sext(k) to d[rd] and opcode 0x18 writes zext(k) to a[rd].
- R6: Opcodes 0x08 (a[rd] = a[rd] + sext(k)) and 0x26 (a[rd] = a[rd] + a[rs]) are plain modulo-2^32 adds and leave the status word unchanged.
- R7: Opcodes 0x0A (add when d15 is nonzero) and 0x0C (add when d15 is zero) compute d[rd] = d[rd] + sext(k) with R3 flag effects when their condition holds. When it does not hold, d[rd] and all status bits keep their values.
- R8: Conditional moves write d[rd] only when their condition holds, otherwise d[rd] is kept. 0x0E writes sext(k) if d15 is nonzero. 0x10 writes sext(k) if d15 is zero. 0x2E writes d[rs] if d15 is nonzero. 0x30 writes d[rs] if d15 is zero.
- R9: Compares write 1 or 0 to d15 using a signed comparison. 0x12 tests d[rd] == sext(k), 0x14 tests d[rd] < sext(k), 0x32 tests d[rd] == d[rs], and 0x34 tests d[rd] < d[rs].
- R10: Without touching the status word, 0x28/0x2A/0x2C write d[rd] AND/OR/XOR d[rs] to d[rd]. In the same way, 0x36 copies d[rs] to d[rd], 0x38 copies d[rs] to a[rd], 0x3A copies a[rs] to a[rd] and 0x3C copies a[rs] to d[rd].
- R11: After reset all 32 registers read zero and `status` reads 0x00000B80. Status bits other than 30, 29, 28 and 27 never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| pc_in | input | 32 | Address of the instruction word |
| next_pc | output | 32 | Address of the following instruction |
| dsel | input | 4 | Data register read select |
| dval | output | 32 | Contents of data register `dsel` |
| asel | input | 4 | Address register read select |
| aval | output | 32 | Contents of address register `asel` |
| status | output | 32 | Status word with overflow flags in bits 30..27 |

## Verification
Four properties are checked on every cycle: the PC step, the hold of the status word across idle cycles and long words, the stickiness of bits 29 and 27, and the fact that a set bit 30 or 28 always comes with its sticky partner. Register results, the choice of sign or zero extension, the predication on d15 and the use of d15 as an implicit operand can only be shown by the bench. Its behavioural model runs the same instruction stream and compares every register and the status word after every clock. The scenarios are overflow by repeated doubling of positive and negative values, conditional operations with d15 both zero and nonzero while the flags are set, signed compares against negative constants, and long or unknown words aimed at registers that hold live values.

// File: rtl/cix_pkg.sv
`timescale 1ns/1ps
package cix_pkg;

    // constant-operand forms
    localparam logic [7:0] OP_ADDC      = 8'h02;
    localparam logic [7:0] OP_ADDC_F15  = 8'h04;
    localparam logic [7:0] OP_ADDC_T15  = 8'h06;
    localparam logic [7:0] OP_ADDAC     = 8'h08;
    localparam logic [7:0] OP_CADDC     = 8'h0A;
    localparam logic [7:0] OP_CADDNC    = 8'h0C;
    localparam logic [7:0] OP_CMOVC     = 8'h0E;
    localparam logic [7:0] OP_CMOVNC    = 8'h10;
    localparam logic [7:0] OP_EQC       = 8'h12;
    localparam logic [7:0] OP_LTC       = 8'h14;
    localparam logic [7:0] OP_MOVC      = 8'h16;
    localparam logic [7:0] OP_MOVAC     = 8'h18;
    // register-operand forms
    localparam logic [7:0] OP_ADD       = 8'h20;
    localparam logic [7:0] OP_ADD_F15   = 8'h22;
    localparam logic [7:0] OP_ADD_T15   = 8'h24;
    localparam logic [7:0] OP_ADDA      = 8'h26;
    localparam logic [7:0] OP_AND       = 8'h28;
    localparam logic [7:0] OP_OR        = 8'h2A;
    localparam logic [7:0] OP_XOR       = 8'h2C;
    localparam logic [7:0] OP_CMOV      = 8'h2E;
    localparam logic [7:0] OP_CMOVN     = 8'h30;
    localparam logic [7:0] OP_EQ        = 8'h32;
    localparam logic [7:0] OP_LT        = 8'h34;
    localparam logic [7:0] OP_MOV       = 8'h36;
    localparam logic [7:0] OP_MOVA      = 8'h38;
    localparam logic [7:0] OP_MOVAA     = 8'h3A;
    localparam logic [7:0] OP_MOVD      = 8'h3C;
    localparam logic [7:0] OP_SUB       = 8'h3E;
    localparam logic [7:0] OP_SUB_F15   = 8'h40;
    localparam logic [7:0] OP_SUB_T15   = 8'h42;

    // status word layout
    localparam int          FLG_V       = 30;
    localparam int          FLG_SV      = 29;
    localparam int          FLG_AV      = 28;
    localparam int          FLG_SAV     = 27;
    localparam logic [31:0] STATUS_RST  = 32'h0000_0B80;

    typedef enum logic [1:0] {SA_DRD, SA_D15, SA_ARD}          srca_e;
    typedef enum logic [1:0] {SB_DRS, SB_CSX, SB_CZX, SB_ARS}  srcb_e;
    typedef enum logic [2:0] {FN_ADD, FN_SUB, FN_AND, FN_OR,
                              FN_XOR, FN_PASS, FN_EQ, FN_LT}   fn_e;
    typedef enum logic [1:0] {DST_NONE, DST_DRD, DST_D15, DST_ARD} dst_e;
    typedef enum logic [1:0] {PR_ALL, PR_NZ, PR_ZR}            pred_e;

    typedef struct packed {
        srca_e sa;
        srcb_e sb;
        fn_e   fn;
        dst_e  dst;
        pred_e pr;
        logic  fl;
    } ctrl_t;

endpackage

// File: rtl/cix_decode.sv
`timescale 1ns/1ps
module cix_decode
    import cix_pkg::*;
(
    input  logic [7:0] opc,
    input  logic       long_word,
    output ctrl_t      ctrl
);

    function automatic ctrl_t mk(srca_e a_sel, srcb_e b_sel, fn_e op,
                                 dst_e d_sel, pred_e p_sel, logic f_en);
        ctrl_t c;
        c.sa  = a_sel;
        c.sb  = b_sel;
        c.fn  = op;
        c.dst = d_sel;
        c.pr  = p_sel;
        c.fl  = f_en;
        return c;
    endfunction

    always_comb begin
        ctrl = mk(SA_DRD, SB_DRS, FN_PASS, DST_NONE, PR_ALL, 1'b0);
        if (!long_word) begin
            case (opc)
                OP_ADDC:     ctrl = mk(SA_DRD, SB_CSX, FN_ADD,  DST_DRD, PR_ALL, 1'b1);
                OP_ADDC_F15: ctrl = mk(SA_D15, SB_CSX, FN_ADD,  DST_DRD, PR_ALL, 1'b1);
                OP_ADDC_T15: ctrl = mk(SA_DRD, SB_CSX, FN_ADD,  DST_D15, PR_ALL, 1'b1);
                OP_ADDAC:    ctrl = mk(SA_ARD, SB_CSX, FN_ADD,  DST_ARD, PR_ALL, 1'b0);
                OP_CADDC:    ctrl = mk(SA_DRD, SB_CSX, FN_ADD,  DST_DRD, PR_NZ,  1'b1);
                OP_CADDNC:   ctrl = mk(SA_DRD, SB_CSX, FN_ADD,  DST_DRD, PR_ZR,  1'b1);
                OP_CMOVC:    ctrl = mk(SA_DRD, SB_CSX, FN_PASS, DST_DRD, PR_NZ,  1'b0);
                OP_CMOVNC:   ctrl = mk(SA_DRD, SB_CSX, FN_PASS, DST_DRD, PR_ZR,  1'b0);
                OP_EQC:      ctrl = mk(SA_DRD, SB_CSX, FN_EQ,   DST_D15, PR_ALL, 1'b0);
                OP_LTC:      ctrl = mk(SA_DRD, SB_CSX, FN_LT,   DST_D15, PR_ALL, 1'b0);
                OP_MOVC:     ctrl = mk(SA_DRD, SB_CSX, FN_PASS, DST_DRD, PR_ALL, 1'b0);
                OP_MOVAC:    ctrl = mk(SA_DRD, SB_CZX, FN_PASS, DST_ARD, PR_ALL, 1'b0);
                OP_ADD:      ctrl = mk(SA_DRD, SB_DRS, FN_ADD,  DST_DRD, PR_ALL, 1'b1);
                OP_ADD_F15:  ctrl = mk(SA_D15, SB_DRS, FN_ADD,  DST_DRD, PR_ALL, 1'b1);
                OP_ADD_T15:  ctrl = mk(SA_DRD, SB_DRS, FN_ADD,  DST_D15, PR_ALL, 1'b1);
                OP_ADDA:     ctrl = mk(SA_ARD, SB_ARS, FN_ADD,  DST_ARD, PR_ALL, 1'b0);
                OP_AND:      ctrl = mk(SA_DRD, SB_DRS, FN_AND,  DST_DRD, PR_ALL, 1'b0);
                OP_OR:       ctrl = mk(SA_DRD, SB_DRS, FN_OR,   DST_DRD, PR_ALL, 1'b0);
                OP_XOR:      ctrl = mk(SA_DRD, SB_DRS, FN_XOR,  DST_DRD, PR_ALL, 1'b0);
                OP_CMOV:     ctrl = mk(SA_DRD, SB_DRS, FN_PASS, DST_DRD, PR_NZ,  1'b0);
                OP_CMOVN:    ctrl = mk(SA_DRD, SB_DRS, FN_PASS, DST_DRD, PR_ZR,  1'b0);
                OP_EQ:       ctrl = mk(SA_DRD, SB_DRS, FN_EQ,   DST_D15, PR_ALL, 1'b0);
                OP_LT:       ctrl = mk(SA_DRD, SB_DRS, FN_LT,   DST_D15, PR_ALL, 1'b0);
                OP_MOV:      ctrl = mk(SA_DRD, SB_DRS, FN_PASS, DST_DRD, PR_ALL, 1'b0);
                OP_MOVA:     ctrl = mk(SA_DRD, SB_DRS, FN_PASS, DST_ARD, PR_ALL, 1'b0);
                OP_MOVAA:    ctrl = mk(SA_DRD, SB_ARS, FN_PASS, DST_ARD, PR_ALL, 1'b0);
                OP_MOVD:     ctrl = mk(SA_DRD, SB_ARS, FN_PASS, DST_DRD, PR_ALL, 1'b0);
                OP_SUB:      ctrl = mk(SA_DRD, SB_DRS, FN_SUB,  DST_DRD, PR_ALL, 1'b1);
                OP_SUB_F15:  ctrl = mk(SA_D15, SB_DRS, FN_SUB,  DST_DRD, PR_ALL, 1'b1);
                OP_SUB_T15:  ctrl = mk(SA_DRD, SB_DRS, FN_SUB,  DST_D15, PR_ALL, 1'b1);
                default:     ctrl = mk(SA_DRD, SB_DRS, FN_PASS, DST_NONE, PR_ALL, 1'b0);
            endcase
        end
    end

endmodule

// File: rtl/cix_alu.sv
`timescale 1ns/1ps
module cix_alu
    import cix_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  fn_e          fn,
    output logic [W-1:0] res,
    output logic         ovf,
    output logic         aovf
);

    logic [W-1:0] sum;
    logic [W-1:0] dif;

    always_comb begin
        sum = opa + opb;
        dif = opa - opb;
        ovf = 1'b0;
        case (fn)
            FN_ADD: begin
                res = sum;
                ovf = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
            end
            FN_SUB: begin
                res = dif;
                ovf = (opa[W-1] != opb[W-1]) && (dif[W-1] != opa[W-1]);
            end
            FN_AND:  res = opa & opb;
            FN_OR:   res = opa | opb;
            FN_XOR:  res = opa ^ opb;
            FN_EQ:   res = {{(W-1){1'b0}}, (opa == opb)};
            FN_LT:   res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: res = opb;
        endcase
        // advance overflow: the two top result bits disagree
        aovf = res[W-1] ^ res[W-2];
    end

endmodule

// File: rtl/cix_regbank.sv
`timescale 1ns/1ps
module cix_regbank #(
    parameter int W  = 32,
    parameter int N  = 16,
    localparam int AW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [W-1:0]         wdata,
    output logic [N-1:0][W-1:0]  q
);

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/cix_unit.sv
`timescale 1ns/1ps
module cix_unit
    import cix_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG),
    localparam int KW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] pc_in,
    output logic [XLEN-1:0] next_pc,
    input  logic [RW-1:0]   dsel,
    output logic [XLEN-1:0] dval,
    input  logic [RW-1:0]   asel,
    output logic [XLEN-1:0] aval,
    output logic [31:0]     status
);

    localparam logic [RW-1:0] CREG = RW'(NREG - 1);

    logic [7:0]              opc;
    logic [RW-1:0]           f_rd;
    logic [RW-1:0]           f_rs;
    logic [KW-1:0]           kcon;
    logic                    long_word;
    logic                    unused_hi;
    ctrl_t                   ctrl;
    logic [NREG-1:0][XLEN-1:0] dq;
    logic [NREG-1:0][XLEN-1:0] aq;
    logic [XLEN-1:0]         d15;
    logic [XLEN-1:0]         opa;
    logic [XLEN-1:0]         opb;
    logic [XLEN-1:0]         res;
    logic                    ovf;
    logic                    aovf;
    logic                    cond_ok;
    logic                    act;
    logic                    d_we;
    logic                    a_we;
    logic [RW-1:0]           d_waddr;
    logic [31:0]             stat_q;

    // field extraction
    assign opc       = instr[7:0];
    assign f_rd      = instr[8 +: RW];
    assign f_rs      = instr[12 +: RW];
    assign kcon      = instr[15:12];
    assign long_word = instr[0];
    assign unused_hi = ^instr[31:16];

    // length-driven PC step
    assign next_pc = pc_in + (long_word ? XLEN'(4) : XLEN'(2));

    cix_decode u_dec (
        .opc       (opc),
        .long_word (long_word),
        .ctrl      (ctrl)
    );

    cix_regbank #(.W(XLEN), .N(NREG)) u_dbank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (d_we),
        .waddr (d_waddr),
        .wdata (res),
        .q     (dq)
    );

    cix_regbank #(.W(XLEN), .N(NREG)) u_abank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (a_we),
        .waddr (f_rd),
        .wdata (res),
        .q     (aq)
    );

    assign d15 = dq[CREG];

    // operand selection
    always_comb begin
        case (ctrl.sa)
            SA_D15:  opa = d15;
            SA_ARD:  opa = aq[f_rd];
            default: opa = dq[f_rd];
        endcase
        case (ctrl.sb)
            SB_CSX:  opb = {{(XLEN-KW){kcon[KW-1]}}, kcon};
            SB_CZX:  opb = {{(XLEN-KW){1'b0}}, kcon};
            SB_ARS:  opb = aq[f_rs];
            default: opb = dq[f_rs];
        endcase
    end

    cix_alu #(.W(XLEN)) u_alu (
        .opa  (opa),
        .opb  (opb),
        .fn   (ctrl.fn),
        .res  (res),
        .ovf  (ovf),
        .aovf (aovf)
    );

    // predication on d15
    always_comb begin
        case (ctrl.pr)
            PR_NZ:   cond_ok = (d15 != '0);
            PR_ZR:   cond_ok = (d15 == '0);
            default: cond_ok = 1'b1;
        endcase
    end

    assign act     = in_valid && !long_word && cond_ok;
    assign d_we    = act && ((ctrl.dst == DST_DRD) || (ctrl.dst == DST_D15));
    assign a_we    = act && (ctrl.dst == DST_ARD);
    assign d_waddr = (ctrl.dst == DST_D15) ? CREG : f_rd;

    // status word: live and sticky overflow bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= STATUS_RST;
        end else if (act && ctrl.fl) begin
            stat_q[FLG_V]   <= ovf;
            stat_q[FLG_SV]  <= stat_q[FLG_SV] | ovf;
            stat_q[FLG_AV]  <= aovf;
            stat_q[FLG_SAV] <= stat_q[FLG_SAV] | aovf;
        end
    end

    assign dval   = dq[dsel];
    assign aval   = aq[asel];
    assign status = stat_q;

endmodule

// File: rtl/cix_chk.sv
`timescale 1ns/1ps
module cix_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [31:0] pc_in,
    input logic [31:0] next_pc,
    input logic [31:0] status
);

    // R1: PC advances by the length given by bit 0
    p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (next_pc - pc_in) == (instr[0] ? 32'd4 : 32'd2));

    // R2: long words leave the status word alone
    p_long_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[0]) |=> $stable(status));

    // R2: idle cycles leave the status word alone
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(status));

    // R3: sticky overflow bit never clears
    p_sv_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status[29] |=> status[29]);

    // R3: sticky advance-overflow bit never clears
    p_sav_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status[27] |=> status[27]);

    // R3: a live overflow is always accompanied by its sticky copy
    p_v_has_sv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status[30] |-> status[29]);

    // R3: a live advance overflow is always accompanied by its sticky copy
    p_av_has_sav_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status[28] |-> status[27]);

endmodule

bind cix_unit cix_chk u_chk (.*);

// File: tb/sim_cix_unit.sv
`timescale 1ns/1ps
module sim_cix_unit;

    localparam logic [7:0] K_ADDC = 8'h02, K_ADDC_F15 = 8'h04, K_ADDC_T15 = 8'h06,
                           K_ADDAC = 8'h08, K_CADDC = 8'h0A, K_CADDNC = 8'h0C,
                           K_CMOVC = 8'h0E, K_CMOVNC = 8'h10, K_EQC = 8'h12,
                           K_LTC = 8'h14, K_MOVC = 8'h16, K_MOVAC = 8'h18;
    localparam logic [7:0] K_ADD = 8'h20, K_ADD_F15 = 8'h22, K_ADD_T15 = 8'h24,
                           K_ADDA = 8'h26, K_AND = 8'h28, K_OR = 8'h2A, K_XOR = 8'h2C,
                           K_CMOV = 8'h2E, K_CMOVN = 8'h30, K_EQ = 8'h32, K_LT = 8'h34,
                           K_MOV = 8'h36, K_MOVA = 8'h38, K_MOVAA = 8'h3A, K_MOVD = 8'h3C,
                           K_SUB = 8'h3E, K_SUB_F15 = 8'h40, K_SUB_T15 = 8'h42;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc_in = '0;
    logic [3:0]  dsel = '0;
    logic [3:0]  asel = '0;
    logic [31:0] next_pc, dval, aval, status;

    cix_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .pc_in(pc_in), .next_pc(next_pc), .dsel(dsel), .dval(dval),
        .asel(asel), .aval(aval), .status(status)
    );

    always #2.5 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [31:0] md [16];
    logic [31:0] ma [16];
    logic [31:0] mpc;
    bit mv, msv, mav, msav;

    function automatic logic [31:0] mstatus();
        return {1'b0, mv, msv, mav, msav, 27'hB80};
    endfunction

    function automatic logic [31:0] ins(logic [7:0] op, int rd, int rs);
        return {16'h0, rs[3:0], rd[3:0], op};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic arith(input logic [31:0] x, input logic [31:0] y,
                         input bit sub, output logic [31:0] r);
        longint xl, yl, s;
        xl = longint'($signed(x));
        yl = longint'($signed(y));
        s  = sub ? (xl - yl) : (xl + yl);
        r  = s[31:0];
        mv = (s > longint'(32'h7FFF_FFFF)) || (s < -longint'(32'h8000_0000));
        mav = r[31] ^ r[30];
        msv = msv | mv;
        msav = msav | mav;
    endtask

    task automatic model(input logic [31:0] w);
        logic [7:0]  op;
        logic [3:0]  rd, rs;
        logic [31:0] sx, zx, t;
        op = w[7:0];
        rd = w[11:8];
        rs = w[15:12];
        sx = {{28{w[15]}}, w[15:12]};
        zx = {28'h0, w[15:12]};
        mpc = mpc + (w[0] ? 32'd4 : 32'd2);
        if (!w[0]) begin
            case (op)
                K_ADDC:     begin arith(md[rd], sx, 1'b0, t); md[rd] = t; end
                K_ADDC_F15: begin arith(md[15], sx, 1'b0, t); md[rd] = t; end
                K_ADDC_T15: begin arith(md[rd], sx, 1'b0, t); md[15] = t; end
                K_ADDAC:    ma[rd] = ma[rd] + sx;
                K_CADDC:    if (md[15] != 0) begin arith(md[rd], sx, 1'b0, t); md[rd] = t; end
                K_CADDNC:   if (md[15] == 0) begin arith(md[rd], sx, 1'b0, t); md[rd] = t; end
                K_CMOVC:    if (md[15] != 0) md[rd] = sx;
                K_CMOVNC:   if (md[15] == 0) md[rd] = sx;
                K_EQC:      md[15] = (md[rd] == sx) ? 32'd1 : 32'd0;
                K_LTC:      md[15] = ($signed(md[rd]) < $signed(sx)) ? 32'd1 : 32'd0;
                K_MOVC:     md[rd] = sx;
                K_MOVAC:    ma[rd] = zx;
                K_ADD:      begin arith(md[rd], md[rs], 1'b0, t); md[rd] = t; end
                K_ADD_F15:  begin arith(md[15], md[rs], 1'b0, t); md[rd] = t; end
                K_ADD_T15:  begin arith(md[rd], md[rs], 1'b0, t); md[15] = t; end
                K_ADDA:     ma[rd] = ma[rd] + ma[rs];
                K_AND:      md[rd] = md[rd] & md[rs];
                K_OR:       md[rd] = md[rd] | md[rs];
                K_XOR:      md[rd] = md[rd] ^ md[rs];
                K_CMOV:     if (md[15] != 0) md[rd] = md[rs];
                K_CMOVN:    if (md[15] == 0) md[rd] = md[rs];
                K_EQ:       md[15] = (md[rd] == md[rs]) ? 32'd1 : 32'd0;
                K_LT:       md[15] = ($signed(md[rd]) < $signed(md[rs])) ? 32'd1 : 32'd0;
                K_MOV:      md[rd] = md[rs];
                K_MOVA:     ma[rd] = md[rs];
                K_MOVAA:    ma[rd] = ma[rs];
                K_MOVD:     md[rd] = ma[rs];
                K_SUB:      begin arith(md[rd], md[rs], 1'b1, t); md[rd] = t; end
                K_SUB_F15:  begin arith(md[15], md[rs], 1'b1, t); md[rd] = t; end
                K_SUB_T15:  begin arith(md[rd], md[rs], 1'b1, t); md[15] = t; end
                default: ;
            endcase
        end
    endtask

    task automatic cmp_all(input string tag);
        for (int i = 0; i < 16; i++) begin
            dsel = i[3:0];
            asel = i[3:0];
            #0.05;
            chk(dval === md[i], tag, $sformatf("d%0d", i), dval, md[i]);
            chk(aval === ma[i], tag, $sformatf("a%0d", i), aval, ma[i]);
        end
        chk(status === mstatus(), tag, "status", status, mstatus());
    endtask

    task automatic step(input logic [31:0] w, input string tag);
        logic [31:0] exp_pc;
        @(negedge clk);
        instr = w;
        pc_in = mpc;
        in_valid = 1'b1;
        exp_pc = mpc + (w[0] ? 32'd4 : 32'd2);
        #0.5;
        chk(next_pc === exp_pc, "R1", "next_pc", next_pc, exp_pc);
        model(w);
        @(posedge clk);
        #0.3;
        in_valid = 1'b0;
        cmp_all(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            md[i] = '0;
            ma[i] = '0;
        end
        {mv, msv, mav, msav} = 4'b0;
        mpc = 32'hFFFF_FFE8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.3;
        cmp_all("R11");

        // R5: constant extension
        step(ins(K_MOVC, 1, 7), "R5");
        step(ins(K_MOVC, 2, 8), "R5");
        step(ins(K_MOVAC, 3, 15), "R5");
        step(ins(K_MOVAC, 4, 8), "R5");

        // R6: address adds, no flags
        step(ins(K_ADDAC, 3, 15), "R6");
        for (int k = 0; k < 30; k++) step(ins(K_ADDA, 3, 3), "R6");
        step(ins(K_ADDA, 4, 3), "R6");

        // R3: overflow by repeated doubling, positive then negative
        for (int k = 0; k < 30; k++) step(ins(K_ADD, 1, 1), "R3");
        step(ins(K_ADDC, 1, 1), "R3");
        for (int k = 0; k < 30; k++) step(ins(K_ADD, 2, 2), "R3");
        step(ins(K_MOVC, 5, 3), "R5");
        step(ins(K_SUB, 5, 2), "R3");
        step(ins(K_SUB, 5, 1), "R3");
        step(ins(K_SUB, 5, 5), "R3");

        // R7: conditional add with flags live
        step(ins(K_MOVD, 9, 3), "R10");
        step(ins(K_ADD, 9, 9), "R3");
        step(ins(K_MOVC, 15, 0), "R7");
        step(ins(K_CADDC, 9, 3), "R7");
        step(ins(K_CADDNC, 9, 3), "R7");
        step(ins(K_MOVC, 15, 1), "R7");
        step(ins(K_CADDNC, 9, 2), "R7");
        step(ins(K_CADDC, 9, 15), "R7");
        step(ins(K_MOVC, 10, 7), "R7");
        step(ins(K_CADDC, 10, 1), "R7");

        // R4: d15 as implicit source or destination
        step(ins(K_MOVC, 15, 3), "R4");
        step(ins(K_ADDC_F15, 6, 5), "R4");
        step(ins(K_ADDC_T15, 6, 14), "R4");
        step(ins(K_ADD_F15, 7, 6), "R4");
        step(ins(K_ADD_T15, 7, 1), "R4");
        step(ins(K_SUB_F15, 8, 6), "R4");
        step(ins(K_SUB_T15, 8, 7), "R4");

        // R8: conditional moves
        step(ins(K_MOVC, 15, 0), "R8");
        step(ins(K_CMOVC, 11, 9), "R8");
        step(ins(K_CMOVNC, 11, 9), "R8");
        step(ins(K_CMOV, 12, 1), "R8");
        step(ins(K_CMOVN, 12, 6), "R8");
        step(ins(K_MOVC, 15, 2), "R8");
        step(ins(K_CMOVNC, 11, 4), "R8");
        step(ins(K_CMOVC, 11, 4), "R8");
        step(ins(K_CMOVN, 12, 7), "R8");
        step(ins(K_CMOV, 12, 7), "R8");

        // R9: signed compares
        step(ins(K_MOVC, 13, 13), "R9");
        step(ins(K_LTC, 13, 2), "R9");
        step(ins(K_LTC, 13, 8), "R9");
        step(ins(K_EQC, 13, 13), "R9");
        step(ins(K_EQC, 13, 12), "R9");
        step(ins(K_LT, 13, 6), "R9");
        step(ins(K_LT, 6, 13), "R9");
        step(ins(K_EQ, 13, 13), "R9");
        step(ins(K_EQ, 13, 6), "R9");

        // R10: logic and moves
        step(ins(K_MOV, 14, 1), "R10");
        step(ins(K_AND, 14, 2), "R10");
        step(ins(K_OR, 14, 6), "R10");
        step(ins(K_XOR, 14, 13), "R10");
        step(ins(K_MOVA, 5, 14), "R10");
        step(ins(K_MOVAA, 6, 5), "R10");
        step(ins(K_MOVD, 0, 6), "R10");

        // R2: long words, unknown opcodes, idle cycles
        step(32'hABCD_1121, "R2");
        step(32'h0000_1103, "R2");
        step(32'h1234_9F37, "R2");
        step(ins(8'h80, 1, 1), "R2");
        step(ins(8'hFE, 15, 3), "R2");
        step(32'hFFFF_3E21, "R2");
        @(negedge clk);
        instr = ins(K_MOVC, 1, 5);
        in_valid = 1'b0;
        @(posedge clk);
        #0.3;
        cmp_all("R2");

        // R11: reset returns everything to its initial state
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            md[i] = '0;
            ma[i] = '0;
        end
        {mv, msv, mav, msav} = 4'b0;
        #0.3;
        cmp_all("R11");
        @(negedge clk);
        rst_n = 1'b1;
        step(ins(K_ADDC, 0, 1), "R3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule